// File: doc/BRIEF.md
# Instruction Word Decoder

This block decodes one 32-bit instruction word of a small load/store machine whose encodings follow the RV32I base layout. It is purely combinational. Within the same cycle it splits the word into register indices and function fields, rebuilds the sign-extended immediate for whichever format the opcode selects, and reduces the opcode and function fields to a compact ALU operation code plus a set of control strobes for the datapath that follows.

Every supported operation is decoded. This covers register and immediate arithmetic, loads, stores, conditional branches, the two jumps, the two upper-immediate forms, the fence no-op and three system patterns: call, break, and an "unimplemented" trap encoding. Bit patterns outside the supported set raise `illegal_o` and force every enable low. Where the encoding leaves a field free, the field is ignored: the 25 bits above the fence opcode, the function-7 field of register OR and AND, and the destination field of the system patterns.

Top module: `instr_decoder`

## Requirements
- R1: `rd_o`=instr[11:7], `rs1_o`=instr[19:15], `rs2_o`=instr[24:20], `funct3_o`=instr[14:12] and `funct7_o`=instr[31:25] for every input word, legal or not.
- R2: I-format immediates (loads, jalr, non-shift OP-IMM) are instr[31:20] sign-extended. S-format immediates (stores, opcode 0100011) are {instr[31:25], instr[11:7]} sign-extended.
- R3: B-format (opcode 1100011) rebuilds {instr[31], instr[7], instr[30:25], instr[11:8], 0}. J-format (opcode 1101111) rebuilds {instr[31], instr[19:12], instr[20], instr[30:21], 0}. Both are sign-extended from instr[31].
- R4: U-format (opcodes 0110111, 0010111) yields {instr[31:12], 12'b0}. Immediate shifts yield instr[24:20] zero-extended. Register ops, fence, system and illegal words yield 0.
- R5: Opcode 0110011 maps funct3/funct7 as follows: 000/0000000 to ADD(0), 000/0100000 to SUB(1), 001/0 to SLL(2), 010/0 to SLT(3), 011/0 to SLTU(4), 100/0 to XOR(5), 101/0 to SRL(6), 101/0100000 to SRA(7). Each has `reg_wr_o`=1 and `alu_b_imm_o`=0.
- R6: Register OR (funct3 110, code 8) and AND (funct3 111, code 9) decode the same for any funct7 value.
- R7: Opcode 0010011 decodes ADD, SLT, SLTU, XOR, OR and AND by funct3 (000, 010, 011, 100, 110, 111). SLL needs funct3 001 with funct7 0. SRL and SRA need funct3 101 with funct7 0 or 0100000. All have `reg_wr_o`=1 and `alu_b_imm_o`=1.
- R8: Loads (0000011, funct3 in {000,001,010,100,101}) give ADD, `mem_rd_o`, `reg_wr_o` and `alu_b_imm_o`. Stores (0100011, funct3 in {000,001,010}) give ADD, `mem_wr_o` and `alu_b_imm_o` with `reg_wr_o`=0.
- R9: Branches (funct3 000/001 to SUB, 100/101 to SLT, 110/111 to SLTU) set `branch_o` and `alu_b_imm_o`=0. JAL and JALR (1100111, funct3 000 only) set `jump_o`, `reg_wr_o`, `alu_b_imm_o` and ADD. LUI gives PASS(10) and AUIPC gives ADD, both with `reg_wr_o` and `alu_b_imm_o`.
- R10: Opcode 0001111 with any upper 25 bits sets `fence_o` only, with ALU code NOP(15).
- R11: Opcode 1110011 with instr[31:12] of 0x00000, 0x00100 or 0xC0001 sets `sys_o` with `sys_kind_o` 1 (call), 2 (break) or 3 (unimplemented) respectively, for any instr[11:7]. No register or memory enable is set. `sys_kind_o` is 0 for every other word.
- R12: Every other word sets `illegal_o`, drives ALU code NOP(15), and holds every enable and flag low.
- R13: `mem_rd_o` and `mem_wr_o` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| funct3_o | output | 3 | Function-3 field (memory width / branch condition) |
| funct7_o | output | 7 | Function-7 field |
| imm_o | output | 32 | Reconstructed immediate |
| alu_op_o | output | 4 | ALU operation code |
| alu_b_imm_o | output | 1 | ALU second operand is the immediate |
| reg_wr_o | output | 1 | Destination register write enable |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | Unconditional jump |
| fence_o | output | 1 | Fence (no-op) |
| sys_o | output | 1 | System pattern recognised |
| sys_kind_o | output | 2 | 0 none, 1 call, 2 break, 3 unimplemented |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The checker evaluates its properties whenever the outputs change. It therefore relies on `instr_i` being a fully driven two-state value and treats every settled combination of outputs as a legal observation, because the block holds no state. The bench changes `instr_i` only on the falling clock edge and reads the outputs one nanosecond later, so every check and every assertion sees a settled decode of a single word. Each stimulus word is built by encoder functions in the bench from named fields, and the free fields get deliberately irregular values to show that the decoder ignores them.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int unsigned ILEN  = 32;
  localparam int unsigned OPC_W = 7;
  localparam int unsigned REG_W = 5;
  localparam int unsigned F3_W  = 3;
  localparam int unsigned F7_W  = 7;
  localparam int unsigned UP_W  = 20;
  localparam int unsigned ALU_W = 4;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD  = 4'd0,  ALU_SUB  = 4'd1,  ALU_SLL = 4'd2, ALU_SLT = 4'd3,
    ALU_SLTU = 4'd4,  ALU_XOR  = 4'd5,  ALU_SRL = 4'd6, ALU_SRA = 4'd7,
    ALU_OR   = 4'd8,  ALU_AND  = 4'd9,  ALU_PASS = 4'd10, ALU_NOP = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    FMT_NONE, FMT_I, FMT_SH, FMT_S, FMT_B, FMT_U, FMT_J
  } fmt_e;

  typedef enum logic [1:0] {
    SYS_NONE = 2'd0, SYS_CALL = 2'd1, SYS_BREAK = 2'd2, SYS_UNIMP = 2'd3
  } sys_e;

  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_FENCE  = 7'b0001111;
  localparam logic [OPC_W-1:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  localparam logic [UP_W-1:0] SYS_UP_CALL  = 20'h00000;
  localparam logic [UP_W-1:0] SYS_UP_BREAK = 20'h00100;
  localparam logic [UP_W-1:0] SYS_UP_UNIMP = 20'hC0001;

  typedef struct packed {
    alu_op_e alu_op;
    fmt_e    fmt;
    logic    b_imm;
    logic    reg_wr;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    jump;
    logic    fence;
    logic    sys;
    sys_e    sys_kind;
    logic    illegal;
  } ctrl_t;

  // Immediate reconstruction, one function per format.
  function automatic logic [ILEN-1:0] imm_of_i(input logic [ILEN-1:0] w);
    return {{20{w[31]}}, w[31:20]};
  endfunction

  function automatic logic [ILEN-1:0] imm_of_s(input logic [ILEN-1:0] w);
    return {{20{w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [ILEN-1:0] imm_of_b(input logic [ILEN-1:0] w);
    return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  function automatic logic [ILEN-1:0] imm_of_u(input logic [ILEN-1:0] w);
    return {w[31:12], 12'b0};
  endfunction

  function automatic logic [ILEN-1:0] imm_of_j(input logic [ILEN-1:0] w);
    return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  function automatic logic [ILEN-1:0] imm_of_sh(input logic [ILEN-1:0] w);
    return {27'b0, w[24:20]};
  endfunction
endpackage

// File: rtl/instr_imm_gen.sv
module instr_imm_gen
  import instr_dec_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  input  fmt_e            fmt_i,
  output logic [ILEN-1:0] imm_o
);
  logic [OPC_W-1:0] unused_opc;
  assign unused_opc = instr_i[OPC_W-1:0];

  always_comb begin
    unique case (fmt_i)
      FMT_I:   imm_o = imm_of_i(instr_i);
      FMT_SH:  imm_o = imm_of_sh(instr_i);
      FMT_S:   imm_o = imm_of_s(instr_i);
      FMT_B:   imm_o = imm_of_b(instr_i);
      FMT_U:   imm_o = imm_of_u(instr_i);
      FMT_J:   imm_o = imm_of_j(instr_i);
      default: imm_o = '0;
    endcase
  end
endmodule

// File: rtl/instr_op_classify.sv
module instr_op_classify
  import instr_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [F3_W-1:0]  f3_i,
  input  logic [UP_W-1:0]  upper_i,
  output ctrl_t            ctrl_o
);
  logic [F7_W-1:0] f7;
  logic            f7_base;
  logic            f7_alt;
  logic            ok;
  ctrl_t           c;

  assign f7      = upper_i[UP_W-1 -: F7_W];
  assign f7_base = (f7 == F7_BASE);
  assign f7_alt  = (f7 == F7_ALT);

  always_comb begin
    c.alu_op   = ALU_NOP;
    c.fmt      = FMT_NONE;
    c.b_imm    = 1'b0;
    c.reg_wr   = 1'b0;
    c.mem_rd   = 1'b0;
    c.mem_wr   = 1'b0;
    c.branch   = 1'b0;
    c.jump     = 1'b0;
    c.fence    = 1'b0;
    c.sys      = 1'b0;
    c.sys_kind = SYS_NONE;
    c.illegal  = 1'b0;
    ok         = 1'b1;

    unique case (opc_i)
      OPC_LUI: begin
        c.fmt = FMT_U; c.alu_op = ALU_PASS; c.b_imm = 1'b1; c.reg_wr = 1'b1;
      end
      OPC_AUIPC: begin
        c.fmt = FMT_U; c.alu_op = ALU_ADD; c.b_imm = 1'b1; c.reg_wr = 1'b1;
      end
      OPC_JAL: begin
        c.fmt = FMT_J; c.alu_op = ALU_ADD; c.b_imm = 1'b1; c.reg_wr = 1'b1;
        c.jump = 1'b1;
      end
      OPC_JALR: begin
        c.fmt = FMT_I; c.alu_op = ALU_ADD; c.b_imm = 1'b1; c.reg_wr = 1'b1;
        c.jump = 1'b1;
        ok = (f3_i == 3'b000);
      end
      OPC_BRANCH: begin
        c.fmt = FMT_B; c.branch = 1'b1;
        unique case (f3_i[2:1])
          2'b00:   c.alu_op = ALU_SUB;
          2'b10:   c.alu_op = ALU_SLT;
          2'b11:   c.alu_op = ALU_SLTU;
          default: ok = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        c.fmt = FMT_I; c.alu_op = ALU_ADD; c.b_imm = 1'b1; c.reg_wr = 1'b1;
        c.mem_rd = 1'b1;
        ok = (f3_i != 3'b011) && (f3_i != 3'b110) && (f3_i != 3'b111);
      end
      OPC_STORE: begin
        c.fmt = FMT_S; c.alu_op = ALU_ADD; c.b_imm = 1'b1; c.mem_wr = 1'b1;
        ok = (f3_i[2] == 1'b0) && (f3_i != 3'b011);
      end
      OPC_OPIMM: begin
        c.fmt = FMT_I; c.b_imm = 1'b1; c.reg_wr = 1'b1;
        unique case (f3_i)
          3'b000: c.alu_op = ALU_ADD;
          3'b010: c.alu_op = ALU_SLT;
          3'b011: c.alu_op = ALU_SLTU;
          3'b100: c.alu_op = ALU_XOR;
          3'b110: c.alu_op = ALU_OR;
          3'b111: c.alu_op = ALU_AND;
          3'b001: begin
            c.fmt = FMT_SH; c.alu_op = ALU_SLL; ok = f7_base;
          end
          default: begin
            c.fmt = FMT_SH;
            c.alu_op = f7_alt ? ALU_SRA : ALU_SRL;
            ok = f7_base || f7_alt;
          end
        endcase
      end
      OPC_OP: begin
        c.reg_wr = 1'b1;
        unique case (f3_i)
          3'b000: begin c.alu_op = f7_alt ? ALU_SUB : ALU_ADD; ok = f7_base || f7_alt; end
          3'b001: begin c.alu_op = ALU_SLL;  ok = f7_base; end
          3'b010: begin c.alu_op = ALU_SLT;  ok = f7_base; end
          3'b011: begin c.alu_op = ALU_SLTU; ok = f7_base; end
          3'b100: begin c.alu_op = ALU_XOR;  ok = f7_base; end
          3'b101: begin c.alu_op = f7_alt ? ALU_SRA : ALU_SRL; ok = f7_base || f7_alt; end
          3'b110: c.alu_op = ALU_OR;
          default: c.alu_op = ALU_AND;
        endcase
      end
      OPC_FENCE: c.fence = 1'b1;
      OPC_SYSTEM: begin
        c.sys = 1'b1;
        if (upper_i == SYS_UP_CALL)       c.sys_kind = SYS_CALL;
        else if (upper_i == SYS_UP_BREAK) c.sys_kind = SYS_BREAK;
        else if (upper_i == SYS_UP_UNIMP) c.sys_kind = SYS_UNIMP;
        else                              ok = 1'b0;
      end
      default: ok = 1'b0;
    endcase

    ctrl_o = c;
    if (!ok) begin
      ctrl_o.alu_op   = ALU_NOP;
      ctrl_o.fmt      = FMT_NONE;
      ctrl_o.b_imm    = 1'b0;
      ctrl_o.reg_wr   = 1'b0;
      ctrl_o.mem_rd   = 1'b0;
      ctrl_o.mem_wr   = 1'b0;
      ctrl_o.branch   = 1'b0;
      ctrl_o.jump     = 1'b0;
      ctrl_o.fence    = 1'b0;
      ctrl_o.sys      = 1'b0;
      ctrl_o.sys_kind = SYS_NONE;
      ctrl_o.illegal  = 1'b1;
    end
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [4:0]  rd_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [2:0]  funct3_o,
  output logic [6:0]  funct7_o,
  output logic [31:0] imm_o,
  output logic [3:0]  alu_op_o,
  output logic        alu_b_imm_o,
  output logic        reg_wr_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic        branch_o,
  output logic        jump_o,
  output logic        fence_o,
  output logic        sys_o,
  output logic [1:0]  sys_kind_o,
  output logic        illegal_o
);
  // Named field taps, also visible to the checker through the ports.
  logic [OPC_W-1:0] opc_w;
  logic [UP_W-1:0]  upper_w;
  ctrl_t            ctrl_w;

  assign opc_w    = instr_i[OPC_W-1:0];
  assign upper_w  = instr_i[ILEN-1 -: UP_W];
  assign rd_o     = instr_i[11:7];
  assign rs1_o    = instr_i[19:15];
  assign rs2_o    = instr_i[24:20];
  assign funct3_o = instr_i[14:12];
  assign funct7_o = instr_i[31:25];

  instr_op_classify u_cls (
    .opc_i   (opc_w),
    .f3_i    (instr_i[14:12]),
    .upper_i (upper_w),
    .ctrl_o  (ctrl_w)
  );

  instr_imm_gen u_imm (
    .instr_i (instr_i),
    .fmt_i   (ctrl_w.fmt),
    .imm_o   (imm_o)
  );

  assign alu_op_o    = ctrl_w.alu_op;
  assign alu_b_imm_o = ctrl_w.b_imm;
  assign reg_wr_o    = ctrl_w.reg_wr;
  assign mem_rd_o    = ctrl_w.mem_rd;
  assign mem_wr_o    = ctrl_w.mem_wr;
  assign branch_o    = ctrl_w.branch;
  assign jump_o      = ctrl_w.jump;
  assign fence_o     = ctrl_w.fence;
  assign sys_o       = ctrl_w.sys;
  assign sys_kind_o  = ctrl_w.sys_kind;
  assign illegal_o   = ctrl_w.illegal;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
  input logic [31:0] instr_i,
  input logic [31:0] imm_o,
  input logic [3:0]  alu_op_o,
  input logic        reg_wr_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        branch_o,
  input logic        jump_o,
  input logic        fence_o,
  input logic        sys_o,
  input logic [1:0]  sys_kind_o,
  input logic        illegal_o
);
  always_comb begin
    p_mem_excl_r13: assert (!(mem_rd_o && mem_wr_o))
      else $error("R13 read and write together");
    if (illegal_o) begin
      p_illegal_quiet_r12: assert (!reg_wr_o && !mem_rd_o && !mem_wr_o && !branch_o &&
                                   !jump_o && !fence_o && !sys_o && alu_op_o == 4'd15 &&
                                   imm_o == 32'd0)
        else $error("R12 illegal word left an enable set");
    end
    if (fence_o) begin
      p_fence_nop_r10: assert (alu_op_o == 4'd15 && !reg_wr_o && !mem_rd_o && !mem_wr_o &&
                               instr_i[6:0] == 7'b0001111)
        else $error("R10 fence not a no-op");
    end
    p_sys_kind_r11: assert (sys_o == (sys_kind_o != 2'd0))
      else $error("R11 system flag and kind disagree");
    if (sys_o) begin
      p_sys_quiet_r11: assert (!reg_wr_o && !mem_rd_o && !mem_wr_o && instr_i[6:0] == 7'b1110011)
        else $error("R11 system word enabled a write");
    end
    if (branch_o || (jump_o && instr_i[3])) begin
      p_offset_even_r3: assert (imm_o[0] == 1'b0 && imm_o[31] == instr_i[31])
        else $error("R3 offset LSB or sign wrong");
    end
    if (!illegal_o && instr_i[6:0] == 7'b0110111) begin
      p_upper_low_zero_r4: assert (imm_o[11:0] == 12'd0 && imm_o[31:12] == instr_i[31:12])
        else $error("R4 upper immediate malformed");
    end
  end
endmodule

bind instr_decoder instr_decoder_chk u_chk (
  .instr_i    (instr_i),
  .imm_o      (imm_o),
  .alu_op_o   (alu_op_o),
  .reg_wr_o   (reg_wr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .branch_o   (branch_o),
  .jump_o     (jump_o),
  .fence_o    (fence_o),
  .sys_o      (sys_o),
  .sys_kind_o (sys_kind_o),
  .illegal_o  (illegal_o)
);

// File: tb/instr_decoder_tb.sv
`timescale 1ns/1ps
module instr_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr;
  logic [4:0]  rd, rs1, rs2;
  logic [2:0]  f3;
  logic [6:0]  f7;
  logic [31:0] imm;
  logic [3:0]  alu;
  logic        bimm, rw, mrd, mwr, br, jmp, fen, sys, ill;
  logic [1:0]  kind;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  instr_decoder u_dut (
    .instr_i(instr), .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2), .funct3_o(f3), .funct7_o(f7),
    .imm_o(imm), .alu_op_o(alu), .alu_b_imm_o(bimm), .reg_wr_o(rw), .mem_rd_o(mrd),
    .mem_wr_o(mwr), .branch_o(br), .jump_o(jmp), .fence_o(fen), .sys_o(sys),
    .sys_kind_o(kind), .illegal_o(ill)
  );

  localparam logic [3:0] A_ADD = 0, A_SUB = 1, A_SLL = 2, A_SLT = 3, A_SLTU = 4,
                         A_XOR = 5, A_SRL = 6, A_SRA = 7, A_OR = 8, A_AND = 9,
                         A_PASS = 10, A_NOP = 15;

  // Encoders build words from fields.
  function automatic logic [31:0] enc_r(logic [6:0] a7, logic [4:0] b, logic [4:0] a,
                                        logic [2:0] q, logic [4:0] d);
    return {a7, b, a, q, d, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(logic [11:0] k, logic [4:0] a, logic [2:0] q,
                                        logic [4:0] d, logic [6:0] op);
    return {k, a, q, d, op};
  endfunction
  function automatic logic [31:0] enc_s(logic [31:0] o, logic [4:0] b, logic [4:0] a, logic [2:0] q);
    return {o[11:5], b, a, q, o[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(logic [31:0] o, logic [4:0] b, logic [4:0] a, logic [2:0] q);
    return {o[12], o[10:5], b, a, q, o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(logic [31:0] o, logic [4:0] d);
    return {o[20], o[10:1], o[11], o[19:12], d, 7'b1101111};
  endfunction

  // Flag vector: {alu, bimm, rw, mrd, mwr, br, jmp, fen, sys, kind, ill}
  function automatic logic [31:0] fl(logic [3:0] a, logic bi, logic w, logic r, logic m,
                                     logic b, logic j, logic f, logic s, logic [1:0] k, logic i);
    return {17'b0, a, bi, w, r, m, b, j, f, s, k, i};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  task automatic expect_dec(input string req, input logic [31:0] exp_fl, input logic [31:0] exp_imm);
    chk(req, "flags", fl(alu, bimm, rw, mrd, mwr, br, jmp, fen, sys, kind, ill), exp_fl);
    chk(req, "imm", imm, exp_imm);
  endtask

  task automatic t_fields;
    apply(enc_r(7'b0100000, 5'd31, 5'd19, 3'b000, 5'd7));
    chk("R1", "rd", {27'b0, rd}, 32'd7);
    chk("R1", "rs1", {27'b0, rs1}, 32'd19);
    chk("R1", "rs2", {27'b0, rs2}, 32'd31);
    apply(32'hFFFF_FFFF);
    chk("R1", "fields of illegal word", {12'b0, f7, f3, rd, rs1}, {12'b0, 7'h7F, 3'h7, 5'h1F, 5'h1F});
  endtask

  task automatic t_reg_ops;
    apply(enc_r(7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3));
    expect_dec("R5 add", fl(A_ADD, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd0);
    apply(enc_r(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd3));
    expect_dec("R5 sub", fl(A_SUB, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd0);
    apply(enc_r(7'b0100000, 5'd2, 5'd1, 3'b101, 5'd3));
    expect_dec("R5 sra", fl(A_SRA, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd0);
    apply(enc_r(7'b0000000, 5'd2, 5'd1, 3'b001, 5'd3));
    expect_dec("R5 sll", fl(A_SLL, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd0);
    apply(enc_r(7'b0000000, 5'd2, 5'd1, 3'b011, 5'd3));
    expect_dec("R5 sltu", fl(A_SLTU, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd0);
    apply(enc_r(7'b1111111, 5'd2, 5'd1, 3'b110, 5'd3));
    expect_dec("R6 or free funct7", fl(A_OR, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd0);
    apply(enc_r(7'b1010101, 5'd2, 5'd1, 3'b111, 5'd3));
    expect_dec("R6 and free funct7", fl(A_AND, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd0);
    apply(enc_r(7'b0000001, 5'd2, 5'd1, 3'b000, 5'd3));
    expect_dec("R12 add bad funct7", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
    apply(enc_r(7'b0100000, 5'd2, 5'd1, 3'b100, 5'd3));
    expect_dec("R12 xor alt funct7", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
  endtask

  task automatic t_imm_ops;
    apply(enc_i(12'hFFB, 5'd4, 3'b000, 5'd9, 7'b0010011));
    expect_dec("R2 R7 addi -5", fl(A_ADD, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'hFFFF_FFFB);
    apply(enc_i(12'h7FF, 5'd4, 3'b010, 5'd9, 7'b0010011));
    expect_dec("R2 R7 slti max", fl(A_SLT, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd2047);
    apply(enc_i(12'h01F, 5'd4, 3'b001, 5'd9, 7'b0010011));
    expect_dec("R4 R7 slli 31", fl(A_SLL, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd31);
    apply(enc_i(12'h403, 5'd4, 3'b101, 5'd9, 7'b0010011));
    expect_dec("R4 R7 srai 3", fl(A_SRA, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd3);
    apply(enc_i(12'h005, 5'd4, 3'b101, 5'd9, 7'b0010011));
    expect_dec("R7 srli 5", fl(A_SRL, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'd5);
    apply(enc_i(12'h821, 5'd4, 3'b001, 5'd9, 7'b0010011));
    expect_dec("R12 slli bad funct7", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
  endtask

  task automatic t_mem;
    apply(enc_i(12'h800, 5'd2, 3'b010, 5'd8, 7'b0000011));
    expect_dec("R2 R8 lw -2048", fl(A_ADD, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0), 32'hFFFF_F800);
    apply(enc_i(12'h00C, 5'd2, 3'b101, 5'd8, 7'b0000011));
    expect_dec("R8 lhu", fl(A_ADD, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0), 32'd12);
    apply(enc_s(32'hFFFF_FFFF, 5'd6, 5'd2, 3'b010));
    expect_dec("R2 R8 sw -1", fl(A_ADD, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0), 32'hFFFF_FFFF);
    apply(enc_s(32'h0000_0123, 5'd6, 5'd2, 3'b000));
    expect_dec("R2 R8 sb 0x123", fl(A_ADD, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0), 32'h123);
    apply(enc_i(12'h004, 5'd2, 3'b011, 5'd8, 7'b0000011));
    expect_dec("R12 load f3 011", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
    apply(enc_s(32'h4, 5'd6, 5'd2, 3'b100));
    expect_dec("R12 store f3 100", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
  endtask

  task automatic t_ctl;
    apply(enc_b(32'hFFFF_FFF8, 5'd2, 5'd1, 3'b000));
    expect_dec("R3 R9 beq -8", fl(A_SUB, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0), 32'hFFFF_FFF8);
    apply(enc_b(32'h0000_0FFE, 5'd2, 5'd1, 3'b111));
    expect_dec("R3 R9 bgeu +4094", fl(A_SLTU, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0), 32'h0000_0FFE);
    apply(enc_b(32'hFFFF_F000, 5'd2, 5'd1, 3'b100));
    expect_dec("R3 R9 blt -4096", fl(A_SLT, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0), 32'hFFFF_F000);
    apply(enc_b(32'h10, 5'd2, 5'd1, 3'b010));
    expect_dec("R12 branch f3 010", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
    apply(enc_j(32'hFFF0_0000, 5'd1));
    expect_dec("R3 R9 jal min", fl(A_ADD, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0), 32'hFFF0_0000);
    apply(enc_j(32'h000F_F802, 5'd1));
    expect_dec("R3 R9 jal mixed", fl(A_ADD, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0), 32'h000F_F802);
    apply(enc_i(12'hFFC, 5'd5, 3'b000, 5'd1, 7'b1100111));
    expect_dec("R2 R9 jalr -4", fl(A_ADD, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0), 32'hFFFF_FFFC);
    apply(enc_i(12'h004, 5'd5, 3'b001, 5'd1, 7'b1100111));
    expect_dec("R12 jalr f3 001", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
    apply({20'hABCDE, 5'd3, 7'b0110111});
    expect_dec("R4 R9 lui", fl(A_PASS, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'hABCD_E000);
    apply({20'h80001, 5'd3, 7'b0010111});
    expect_dec("R4 R9 auipc", fl(A_ADD, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32'h8000_1000);
  endtask

  task automatic t_fence;
    apply({25'h1B5_6DF7, 7'b0001111});
    expect_dec("R10 fence free bits", fl(A_NOP, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0), 32'd0);
    apply({25'h0, 7'b0001111});
    expect_dec("R10 fence zero", fl(A_NOP, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0), 32'd0);
  endtask

  task automatic t_sys;
    apply({20'h00000, 5'd5, 7'b1110011});
    expect_dec("R11 call", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 0), 32'd0);
    chk("R11", "call rd", {27'b0, rd}, 32'd5);
    apply({20'h00100, 5'd0, 7'b1110011});
    expect_dec("R11 break", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 0), 32'd0);
    apply({20'hC0001, 5'h1F, 7'b1110011});
    expect_dec("R11 unimp", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 1, 2'd3, 0), 32'd0);
    apply({20'h00200, 5'd0, 7'b1110011});
    expect_dec("R12 system other", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
    apply({20'hC0000, 5'd0, 7'b1110011});
    expect_dec("R12 system near unimp", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
  endtask

  task automatic t_illegal;
    apply(32'h0000_0000);
    expect_dec("R12 all zero", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
    apply(32'h1234_567F);
    expect_dec("R12 unknown opcode", fl(A_NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), 32'd0);
    chk("R13", "mem strobes exclusive", {30'b0, mrd, mwr} & {30'b0, mrd & mwr, mrd & mwr}, 32'd0);
  endtask

  initial begin
    instr = 32'h0;
    #7 rst_n = 1'b1;
    apply(32'h0);
    chk("R12", "idle word illegal", {31'b0, ill}, 32'd1);
    t_fields();
    t_reg_ops();
    t_imm_ops();
    t_mem();
    t_ctl();
    t_fence();
    t_sys();
    t_illegal();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule